// File: doc/BRIEF.md
# Linked-List Descriptor Loader

This block walks a chain of transfer descriptors kept in memory and feeds them, one at a time, to a transfer sequencer. Each descriptor is a node of four data words read at consecutive word addresses: source address (offset 0), destination address (offset +4 bytes), control word (offset +8) and the address of the next node (offset +12). A start pulse latches the head address, the loader fetches the head node, presents it on a load bus together with a start pulse to the sequencer, and waits for the sequencer's done pulse.

After each done pulse the loader compares the link word of the node just run with the latched head address. The chain is circular, so a match means every node has run: the loader pulses list-done and goes idle without fetching the head node a second time. Otherwise it fetches the node at the link address and repeats. Memory reads use a request valid/ready handshake and a response valid/ready handshake with any latency. Only one read is outstanding at a time. An error response aborts the chain and sets a sticky error flag.

Top module: `ll_desc_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, read-request valid, config-load, transfer-start, list-done and the error flag are all 0.
- R2: A start pulse seen while idle latches the head address. The first read request appears two cycles later at that address. A node's words are requested one at a time at node+0, +4, +8 and +12, in that order, holding source, destination, control and link. Response ready is 1 only while a request is awaiting its response.
- R3: A read request that is not accepted stays valid with an unchanged address in the next cycle.
- R4: Config-load and transfer-start are high together for exactly one cycle, two cycles after the fourth word of a node is accepted. In that cycle source, destination and control carry words 0, 1 and 2 of that node.
- R5: A transfer-done pulse whose node link differs from the head address causes a read request at the link address two cycles later.
- R6: A transfer-done pulse whose node link equals the head address makes list-done high for one cycle in the next cycle, with busy already low. No further read request or load follows.
- R7: An error response aborts the chain. The error flag is high and busy low two cycles after the response, and no load is produced for that node. The flag stays high until the next accepted start, which clears it.
- R8: A start pulse while busy, and a transfer-done pulse while no transfer is running, change nothing: the request addresses and loads of the chain in progress are unaffected.
- R9: Busy is high from the cycle after an accepted start until the chain ends or is aborted.
- R10: A single-node chain, whose link is its own address, is loaded and run once and then ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| head_ptr_i | input | ADDR_W | Address of the first node |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | ADDR_W | Read byte address |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_ready_o | output | 1 | Loader waiting for a response |
| rd_rsp_data_i | input | DATA_W | Read response data |
| rd_rsp_err_i | input | 1 | Read response carries an error |
| cfg_load_o | output | 1 | Load pulse for the channel registers |
| cfg_src_o | output | DATA_W | Source address of current node |
| cfg_dst_o | output | DATA_W | Destination address of current node |
| cfg_ctrl_o | output | DATA_W | Control word of current node |
| xfer_start_o | output | 1 | Start pulse to the transfer sequencer |
| xfer_done_i | input | 1 | Transfer of the current node finished |
| busy_o | output | 1 | Chain in progress |
| list_done_o | output | 1 | Whole chain finished |
| cfg_err_o | output | 1 | Chain aborted by an error response |

## Verification
Every result has a fixed latency from the input that causes it. The first request of a chain comes two cycles after start, and the next node's request two cycles after transfer-done. The load pulse comes two cycles after the last word of a node is accepted, and the error flag two cycles after an error response. List-done comes one cycle after the final transfer-done. The bench plays the memory and the sequencer cycle by cycle and records the cycle in which it drives each cause. It then checks that the matching output is present in exactly the due cycle and absent in every other, sampling half a period after the edge.

// File: rtl/ll_desc_pkg.sv
package ll_desc_pkg;

    // node layout: word index within a node, fixed by the read order
    localparam int unsigned NODE_WORDS = 4;
    localparam int unsigned W_SRC      = 0;
    localparam int unsigned W_DST      = 1;
    localparam int unsigned W_CTL      = 2;
    localparam int unsigned W_LINK     = 3;

    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_RSP
    } fetch_st_e;

    typedef enum logic [1:0] {
        C_IDLE,
        C_FETCH,
        C_ISSUE,
        C_RUN
    } chain_st_e;

endpackage

// File: rtl/ll_node_fetch.sv
module ll_node_fetch
    import ll_desc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 go_i,
    input  logic [ADDR_W-1:0]                    base_i,
    output logic                                 req_valid_o,
    input  logic                                 req_ready_i,
    output logic [ADDR_W-1:0]                    req_addr_o,
    input  logic                                 rsp_valid_i,
    output logic                                 rsp_ready_o,
    input  logic [DATA_W-1:0]                    rsp_data_i,
    input  logic                                 rsp_err_i,
    output logic                                 node_done_o,
    output logic                                 node_err_o,
    output logic [NODE_WORDS-1:0][DATA_W-1:0]    node_o
);

    localparam int unsigned IDX_W      = $clog2(NODE_WORDS);
    localparam int unsigned WORD_BYTES = DATA_W / 8;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);

    typedef struct packed {
        fetch_st_e                          st;
        logic [IDX_W-1:0]                   idx;
        logic [ADDR_W-1:0]                  base;
        logic [NODE_WORDS-1:0][DATA_W-1:0]  words;
        logic                               done;
        logic                               err;
    } fetch_regs_t;

    fetch_regs_t fr_d, fr_q;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        fr_d.err  = 1'b0;
        case (fr_q.st)
            F_IDLE: begin
                if (go_i) begin
                    fr_d.base = base_i;
                    fr_d.idx  = '0;
                    fr_d.st   = F_REQ;
                end
            end
            F_REQ: begin
                if (req_ready_i) fr_d.st = F_RSP;
            end
            F_RSP: begin
                if (rsp_valid_i) begin
                    if (rsp_err_i) begin
                        fr_d.err = 1'b1;
                        fr_d.st  = F_IDLE;
                    end else begin
                        fr_d.words[fr_q.idx] = rsp_data_i;
                        if (fr_q.idx == LAST_IDX) begin
                            fr_d.done = 1'b1;
                            fr_d.st   = F_IDLE;
                        end else begin
                            fr_d.idx = fr_q.idx + 1'b1;
                            fr_d.st  = F_REQ;
                        end
                    end
                end
            end
            default: fr_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign req_valid_o = (fr_q.st == F_REQ);
    assign rsp_ready_o = (fr_q.st == F_RSP);
    assign req_addr_o  = fr_q.base + ADDR_W'(fr_q.idx) * ADDR_W'(WORD_BYTES);
    assign node_done_o = fr_q.done;
    assign node_err_o  = fr_q.err;
    assign node_o      = fr_q.words;

    // R3: a stalled request keeps its address
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

    // R2: a node is complete only right after an accepted good response
    a_r2_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        node_done_o |-> $past(rsp_valid_i && rsp_ready_o && !rsp_err_i));

endmodule

// File: rtl/ll_chain_ctrl.sv
module ll_chain_ctrl
    import ll_desc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic [ADDR_W-1:0]                    head_i,
    output logic                                 go_o,
    output logic [ADDR_W-1:0]                    base_o,
    input  logic                                 node_done_i,
    input  logic                                 node_err_i,
    input  logic [NODE_WORDS-1:0][DATA_W-1:0]    node_i,
    input  logic                                 xfer_done_i,
    output logic                                 cfg_load_o,
    output logic                                 xfer_start_o,
    output logic [DATA_W-1:0]                    cfg_src_o,
    output logic [DATA_W-1:0]                    cfg_dst_o,
    output logic [DATA_W-1:0]                    cfg_ctrl_o,
    output logic                                 busy_o,
    output logic                                 list_done_o,
    output logic                                 cfg_err_o
);

    typedef struct packed {
        chain_st_e          st;
        logic [ADDR_W-1:0]  head;
        logic [ADDR_W-1:0]  link;
        logic [DATA_W-1:0]  src;
        logic [DATA_W-1:0]  dst;
        logic [DATA_W-1:0]  ctl;
        logic               go;
        logic [ADDR_W-1:0]  base;
        logic               fin;
        logic               err;
    } chain_regs_t;

    chain_regs_t cr_d, cr_q;

    always_comb begin
        cr_d     = cr_q;
        cr_d.go  = 1'b0;
        cr_d.fin = 1'b0;
        case (cr_q.st)
            C_IDLE: begin
                if (start_i) begin
                    cr_d.head = head_i;
                    cr_d.base = head_i;
                    cr_d.go   = 1'b1;
                    cr_d.err  = 1'b0;
                    cr_d.st   = C_FETCH;
                end
            end
            C_FETCH: begin
                if (node_err_i) begin
                    cr_d.err = 1'b1;
                    cr_d.st  = C_IDLE;
                end else if (node_done_i) begin
                    cr_d.src  = node_i[W_SRC];
                    cr_d.dst  = node_i[W_DST];
                    cr_d.ctl  = node_i[W_CTL];
                    cr_d.link = node_i[W_LINK][ADDR_W-1:0];
                    cr_d.st   = C_ISSUE;
                end
            end
            C_ISSUE: cr_d.st = C_RUN;
            C_RUN: begin
                if (xfer_done_i) begin
                    if (cr_q.link == cr_q.head) begin
                        cr_d.fin = 1'b1;
                        cr_d.st  = C_IDLE;
                    end else begin
                        cr_d.base = cr_q.link;
                        cr_d.go   = 1'b1;
                        cr_d.st   = C_FETCH;
                    end
                end
            end
            default: cr_d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign go_o         = cr_q.go;
    assign base_o       = cr_q.base;
    assign cfg_load_o   = (cr_q.st == C_ISSUE);
    assign xfer_start_o = (cr_q.st == C_ISSUE);
    assign cfg_src_o    = cr_q.src;
    assign cfg_dst_o    = cr_q.dst;
    assign cfg_ctrl_o   = cr_q.ctl;
    assign busy_o       = (cr_q.st != C_IDLE);
    assign list_done_o  = cr_q.fin;
    assign cfg_err_o    = cr_q.err;

    // R4: a load follows a completed node fetch
    a_r4_load_follows_node: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_load_o) |-> $past(node_done_i));

    // R4: the load pulse lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_o |=> !cfg_load_o);

    // R6: list-done only after a transfer-done, with busy already low
    a_r6_done_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        list_done_o |-> $past(xfer_done_i) && !busy_o);

    // R7: an aborted node is never loaded
    a_r7_err_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        node_err_i |=> !cfg_load_o);

    // R8: the head address does not move while a chain runs
    a_r8_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> $stable(cr_q.head));

endmodule

// File: rtl/ll_desc_loader.sv
module ll_desc_loader
    import ll_desc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] head_ptr_i,
    output logic              rd_req_valid_o,
    input  logic              rd_req_ready_i,
    output logic [ADDR_W-1:0] rd_req_addr_o,
    input  logic              rd_rsp_valid_i,
    output logic              rd_rsp_ready_o,
    input  logic [DATA_W-1:0] rd_rsp_data_i,
    input  logic              rd_rsp_err_i,
    output logic              cfg_load_o,
    output logic [DATA_W-1:0] cfg_src_o,
    output logic [DATA_W-1:0] cfg_dst_o,
    output logic [DATA_W-1:0] cfg_ctrl_o,
    output logic              xfer_start_o,
    input  logic              xfer_done_i,
    output logic              busy_o,
    output logic              list_done_o,
    output logic              cfg_err_o
);

    logic                              go;
    logic [ADDR_W-1:0]                 base;
    logic                              node_done;
    logic                              node_err;
    logic [NODE_WORDS-1:0][DATA_W-1:0] node;

    ll_node_fetch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .base_i      (base),
        .req_valid_o (rd_req_valid_o),
        .req_ready_i (rd_req_ready_i),
        .req_addr_o  (rd_req_addr_o),
        .rsp_valid_i (rd_rsp_valid_i),
        .rsp_ready_o (rd_rsp_ready_o),
        .rsp_data_i  (rd_rsp_data_i),
        .rsp_err_i   (rd_rsp_err_i),
        .node_done_o (node_done),
        .node_err_o  (node_err),
        .node_o      (node)
    );

    ll_chain_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .head_i       (head_ptr_i),
        .go_o         (go),
        .base_o       (base),
        .node_done_i  (node_done),
        .node_err_i   (node_err),
        .node_i       (node),
        .xfer_done_i  (xfer_done_i),
        .cfg_load_o   (cfg_load_o),
        .xfer_start_o (xfer_start_o),
        .cfg_src_o    (cfg_src_o),
        .cfg_dst_o    (cfg_dst_o),
        .cfg_ctrl_o   (cfg_ctrl_o),
        .busy_o       (busy_o),
        .list_done_o  (list_done_o),
        .cfg_err_o    (cfg_err_o)
    );

endmodule

// File: tb/sim_ll_desc_loader.sv
`timescale 1ns/1ps
module sim_ll_desc_loader;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] head_ptr_i;
    logic        rd_req_valid_o;
    logic        rd_req_ready_i;
    logic [31:0] rd_req_addr_o;
    logic        rd_rsp_valid_i;
    logic        rd_rsp_ready_o;
    logic [31:0] rd_rsp_data_i;
    logic        rd_rsp_err_i;
    logic        cfg_load_o;
    logic [31:0] cfg_src_o;
    logic [31:0] cfg_dst_o;
    logic [31:0] cfg_ctrl_o;
    logic        xfer_start_o;
    logic        xfer_done_i;
    logic        busy_o;
    logic        list_done_o;
    logic        cfg_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] mem [64];

    always #2.5 clk = ~clk;

    ll_desc_loader u0 (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] node_addr(input int s, input int k, input int i);
        return 32'(((s + i * k) % 16) * 16);
    endfunction

    task automatic idle_inputs();
        start_i        = 1'b0;
        head_ptr_i     = '0;
        rd_req_ready_i = 1'b0;
        rd_rsp_valid_i = 1'b0;
        rd_rsp_data_i  = '0;
        rd_rsp_err_i   = 1'b0;
        xfer_done_i    = 1'b0;
    endtask

    // n nodes; error injected at node err_node word err_word (err_node < 0: none)
    task automatic run_chain(input int n, input int err_node, input int err_word, input bit noise);
        int s = int'($urandom % 16);
        int k = 2 * int'($urandom % 8) + 1;
        logic [31:0] na [16];
        logic [31:0] es [16];
        logic [31:0] ed [16];
        logic [31:0] ec [16];
        int c = 0, node = 0, word = 0, lat = 0;
        int req_due = 2, load_due = -1, ld_due = -1, err_due = -1, run_wait = -1;
        bit pend = 0, fin = 0, in_fetch = 1, stalled = 0;
        string tg = noise ? "R8" : "R2";
        for (int i = 0; i < n; i++) na[i] = node_addr(s, k, i);
        for (int i = 0; i < n; i++) begin
            es[i] = $urandom; ed[i] = $urandom; ec[i] = $urandom;
            mem[na[i][7:2] + 0] = es[i];
            mem[na[i][7:2] + 1] = ed[i];
            mem[na[i][7:2] + 2] = ec[i];
            mem[na[i][7:2] + 3] = na[(i + 1) % n];
        end
        @(negedge clk);
        idle_inputs();
        start_i = 1'b1; head_ptr_i = na[0];
        @(negedge clk); c = 1;
        chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
        chk(cfg_err_o == 1'b0, "R7 error cleared by start", cfg_err_o, 0);
        while (!fin && c < 4000) begin
            idle_inputs();
            start_i    = noise && busy_o && ($urandom % 6 == 0);
            head_ptr_i = $urandom;
            if (pend) begin
                if (lat == 0) begin
                    rd_rsp_valid_i = 1'b1;
                    rd_rsp_data_i  = mem[na[node][7:2] + 6'(word)];
                    chk(rd_rsp_ready_o, "R2 rsp ready", rd_rsp_ready_o, 1);
                    pend = 0;
                    if (node == err_node && word == err_word) begin
                        rd_rsp_err_i = 1'b1; err_due = c + 2;
                    end else if (word == 3) begin
                        load_due = c + 2; word = 0;
                    end else word++;
                end else lat--;
            end else if (rd_req_valid_o) begin
                if (req_due >= 0)
                    chk(c == req_due, (node == 0) ? "R2 first request cycle" : "R5 next request cycle", c, req_due);
                req_due = -1;
                chk(rd_req_addr_o == na[node] + 32'(4 * word), stalled ? "R3 held address" : tg,
                    rd_req_addr_o, na[node] + 32'(4 * word));
                stalled = 1;
                if ($urandom % 2 == 1) begin
                    rd_req_ready_i = 1'b1; pend = 1; lat = int'($urandom % 4); stalled = 0;
                end
            end else if (req_due >= 0 && c > req_due) begin
                chk(0, "R5 request missing", 0, 1); req_due = -1;
            end
            if (cfg_load_o || c == load_due) begin
                chk(cfg_load_o && c == load_due, "R4 load cycle", c, load_due);
                if (cfg_load_o && node < n) begin
                    chk(xfer_start_o, "R4 start with load", xfer_start_o, 1);
                    chk(cfg_src_o == es[node], noise ? "R8 src" : "R4 src", cfg_src_o, es[node]);
                    chk(cfg_dst_o == ed[node], "R4 dst", cfg_dst_o, ed[node]);
                    chk(cfg_ctrl_o == ec[node], "R4 ctrl", cfg_ctrl_o, ec[node]);
                end
                load_due = -1; in_fetch = 0; run_wait = int'($urandom % 5);
            end else if (run_wait == 0) begin
                xfer_done_i = 1'b1; run_wait = -1; node++;
                if (node == n) ld_due = c + 1;
                else begin req_due = c + 2; in_fetch = 1; end
            end else if (run_wait > 0) run_wait--;
            if (noise && in_fetch && ($urandom % 5 == 0)) xfer_done_i = 1'b1;
            if (list_done_o || c == ld_due) begin
                chk(list_done_o && c == ld_due, (n == 1) ? "R10 single node end" : "R6 end cycle", c, ld_due);
                chk(!busy_o, "R6 busy low at end", busy_o, 0);
                fin = 1;
            end
            if (c == err_due) begin
                chk(cfg_err_o && !busy_o, "R7 abort", {cfg_err_o, busy_o}, 2'b10);
                fin = 1;
            end
            if (!fin) begin @(negedge clk); c++; end
        end
        if (!fin) chk(0, "R6 chain not finished", c, 0);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            idle_inputs();
            chk(!rd_req_valid_o && !cfg_load_o && !busy_o && !list_done_o, "R6 quiet after end",
                {rd_req_valid_o, cfg_load_o, busy_o, list_done_o}, 0);
            chk(cfg_err_o == (err_due >= 0), "R7 sticky flag", cfg_err_o, (err_due >= 0));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R6 watchdog actual=%0d expected=%0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) mem[i] = '0;
        idle_inputs();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk({busy_o, rd_req_valid_o, cfg_load_o, xfer_start_o, list_done_o, cfg_err_o} == 0,
            "R1 reset state", {busy_o, rd_req_valid_o, cfg_load_o, xfer_start_o, list_done_o, cfg_err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, rd_req_valid_o, cfg_load_o, list_done_o, cfg_err_o} == 0,
            "R1 after reset", {busy_o, rd_req_valid_o, cfg_load_o, list_done_o, cfg_err_o}, 0);
        run_chain(1, -1, 0, 0);   // R10
        run_chain(3, -1, 0, 0);
        run_chain(4, 1, 2, 1);    // R7 mid-chain abort
        run_chain(2, 0, 0, 0);    // R7 abort on first word
        run_chain(5, -1, 0, 1);   // R8 noise, R7 flag cleared
        run_chain(16, -1, 0, 0);
        for (int t = 0; t < 25; t++) begin
            automatic int n = 1 + int'($urandom % 8);
            automatic int en = ($urandom % 5 == 0) ? int'($urandom % n) : -1;
            run_chain(n, en, int'($urandom % 4), bit'($urandom % 2));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule